// File: doc/BRIEF.md
# Supply and Pushbutton Reset Stretcher

This block produces the reset for a processor core from two independent causes. The first is a synchronous flag that reports the supply rail as out of tolerance. The second is a mechanical pushbutton, active low and asynchronous to the clock. While either cause is active, the system reset is held asserted. Once the cause clears, the reset stays asserted for a further fixed number of clock cycles so that the supply and the core can settle.

The two causes start the stretch at different points. A supply fault starts it when the flag returns to in-tolerance. A button press starts it when the debounced button is seen released. Brief supply-flag pulses are filtered out so that rail noise cannot reset the system. The button goes through a synchroniser and then a debouncer that needs its level to be stable before a change is accepted. If either cause returns during a stretch, the stretch starts again from the beginning.

The reset is driven in both polarities from separate flops. A one-cycle pulse marks the cycle in which reset goes inactive, so that a watchdog can start timing from that point. Every duration is a parameter counted in clock cycles.

Top module: `rst_stretch_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1, `sys_rst_n` is 0 and `rst_done` is 0.
- R2: After `rst_n` is released, `sys_rst` remains 1 through the STRETCH_CYCLES-th clock edge and falls on edge STRETCH_CYCLES+1, counting the first edge after release as edge 1.
- R3: When `supply_bad` is sampled 1 on FAULT_FILTER_CYCLES consecutive edges, `sys_rst` is 1 from edge FAULT_FILTER_CYCLES+1 onward and stays 1 while `supply_bad` remains 1.
- R4: A `supply_bad` pulse sampled 1 on fewer than FAULT_FILTER_CYCLES consecutive edges leaves `sys_rst` at 0.
- R5: After a qualified supply fault, taking as edge 1 the first edge that samples `supply_bad` at 0, `sys_rst` is still 1 at edge STRETCH_CYCLES+1 and falls on edge STRETCH_CYCLES+2.
- R6: A low level on `btn_n` (0 = pressed) lasting fewer than DEBOUNCE_CYCLES cycles does not assert `sys_rst`.
- R7: A press held long enough asserts `sys_rst` on edge SYNC_STAGES+DEBOUNCE_CYCLES+1 after `btn_n` falls, and holds it while pressed. After release, `sys_rst` falls on edge SYNC_STAGES+DEBOUNCE_CYCLES+STRETCH_CYCLES+1 after `btn_n` rises.
- R8: A qualified supply fault or button press that occurs during a stretch restarts the full stretch from its own recovery or release.
- R9: `rst_done` is 1 for exactly the single cycle in which `sys_rst` has just fallen, and is 0 at all other times.
- R10: `sys_rst_n` is always the complement of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| supply_bad | input | 1 | Synchronous flag, 1 = supply out of tolerance |
| btn_n | input | 1 | Asynchronous pushbutton level, 0 = pressed |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |
| rst_done | output | 1 | One-cycle pulse as system reset goes inactive |

## Verification
The bench drives supply pulses one cycle shorter than the qualifying length. A filter that counts one cycle too few would reset the system on these, and the bench reports them as faults. Button presses one cycle shorter than the debounce window catch a debouncer that accepts the level too early. The exact edge on which reset falls is checked after each kind of recovery and after block reset. An off-by-one in the stretch counter, or a stretch started from the press rather than the release, moves that edge. The bench also injects a second supply fault and a button press in the middle of a running stretch. A design that only extended the old count, or that ignored the new cause, would release reset at the original time.

// File: rtl/rst_stretch_pkg.sv
package rst_stretch_pkg;

  // Which level changes of a filter need qualification.
  typedef enum logic [0:0] {
    FILT_BOTH = 1'b0,   // both directions must be stable for the window
    FILT_RISE = 1'b1    // only a rise is qualified, a fall is taken at once
  } filt_mode_e;

  // Counter width that can hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rst_level_filter.sv
module rst_level_filter
  import rst_stretch_pkg::*;
#(
  parameter int         HOLD_CYCLES = 4,
  parameter filt_mode_e MODE        = FILT_BOTH,
  parameter logic       RST_LVL     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level
);

  localparam int             CW   = cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0]  LAST = CW'(HOLD_CYCLES - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differs;
  logic          qualify;
  logic          cnt_en;

  always_comb differs = (din != lvl_q);

  generate
    if (MODE == FILT_BOTH) begin : g_both
      always_comb qualify = differs;
    end else begin : g_rise
      always_comb qualify = differs & din;
    end
  endgenerate

  // Next-state: a qualified change needs HOLD_CYCLES stable samples,
  // an unqualified change is accepted on the first sample.
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (differs && !qualify) begin
      lvl_d = din;
    end else if (qualify) begin
      if (cnt_q == LAST) begin
        lvl_d = din;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_comb cnt_en = differs | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_LVL;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign level = lvl_q;

endmodule

// File: rtl/rst_stretch_timer.sv
module rst_stretch_timer
  import rst_stretch_pkg::*;
#(
  parameter int STRETCH_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic rst_hi,
  output logic rst_lo,
  output logic done_pulse
);

  localparam int            CW   = cnt_width(STRETCH_CYCLES);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_hi_q, act_lo_q, done_q;
  logic          act_d, done_d;
  logic          cnt_en;

  // Next-state: hold reloads the full stretch, otherwise count down.
  always_comb begin
    cnt_d = cnt_q;
    act_d = 1'b0;
    if (hold) begin
      cnt_d = FULL;
      act_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
      act_d = 1'b1;
    end
  end

  always_comb cnt_en = hold | (cnt_q != '0);
  always_comb done_d = act_hi_q & ~act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= FULL;
      act_hi_q <= 1'b1;
      act_lo_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      act_hi_q <= act_d;
      act_lo_q <= ~act_d;
      done_q   <= done_d;
    end
  end

  assign rst_hi     = act_hi_q;
  assign rst_lo     = act_lo_q;
  assign done_pulse = done_q;

endmodule

// File: rtl/rst_stretch_ctrl.sv
module rst_stretch_ctrl
  import rst_stretch_pkg::*;
#(
  parameter int SYNC_STAGES         = 2,
  parameter int DEBOUNCE_CYCLES     = 30,
  parameter int FAULT_FILTER_CYCLES = 400,
  parameter int STRETCH_CYCLES      = 26000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_bad,
  input  logic btn_n,
  output logic sys_rst,
  output logic sys_rst_n,
  output logic rst_done
);

  logic btn_sync_n;
  logic btn_level_n;
  logic fault_level;
  logic hold;

  rst_sync_chain #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_btn_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (btn_n),
    .q     (btn_sync_n)
  );

  rst_level_filter #(
    .HOLD_CYCLES (DEBOUNCE_CYCLES),
    .MODE        (FILT_BOTH),
    .RST_LVL     (1'b1)
  ) u_btn_debounce (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (btn_sync_n),
    .level (btn_level_n)
  );

  rst_level_filter #(
    .HOLD_CYCLES (FAULT_FILTER_CYCLES),
    .MODE        (FILT_RISE),
    .RST_LVL     (1'b0)
  ) u_fault_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (supply_bad),
    .level (fault_level)
  );

  always_comb hold = fault_level | ~btn_level_n;

  rst_stretch_timer #(
    .STRETCH_CYCLES (STRETCH_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .rst_hi     (sys_rst),
    .rst_lo     (sys_rst_n),
    .done_pulse (rst_done)
  );

endmodule

// File: rtl/rst_stretch_ctrl_chk.sv
module rst_stretch_ctrl_chk #(
  parameter int SYNC_STAGES         = 2,
  parameter int DEBOUNCE_CYCLES     = 30,
  parameter int FAULT_FILTER_CYCLES = 400,
  parameter int STRETCH_CYCLES      = 26000000
) (
  input logic clk,
  input logic rst_n,
  input logic supply_bad,
  input logic btn_n,
  input logic sys_rst,
  input logic sys_rst_n,
  input logic rst_done
);

  localparam int BTN_LIM   = SYNC_STAGES + DEBOUNCE_CYCLES;
  localparam int QUIET_LIM = SYNC_STAGES + DEBOUNCE_CYCLES + STRETCH_CYCLES + 3;

  int fault_run;
  int btn_run;
  int quiet_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_run <= 0;
      btn_run   <= 0;
      quiet_run <= 0;
    end else begin
      fault_run <= !supply_bad ? 0 : (fault_run < FAULT_FILTER_CYCLES ? fault_run + 1 : fault_run);
      btn_run   <= btn_n ? 0 : (btn_run < BTN_LIM ? btn_run + 1 : btn_run);
      quiet_run <= (supply_bad || !btn_n) ? 0 : (quiet_run < QUIET_LIM ? quiet_run + 1 : quiet_run);
    end
  end

  a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n == !sys_rst);

  a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |-> (!sys_rst && $past(sys_rst)));

  a_r9_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> rst_done);

  a_r3_long_fault_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_run >= FAULT_FILTER_CYCLES) |=> sys_rst);

  a_r7_held_button_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_run >= BTN_LIM) |=> sys_rst);

  a_r5_quiet_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_run >= QUIET_LIM) |-> !sys_rst);

endmodule

bind rst_stretch_ctrl rst_stretch_ctrl_chk #(
  .SYNC_STAGES         (SYNC_STAGES),
  .DEBOUNCE_CYCLES     (DEBOUNCE_CYCLES),
  .FAULT_FILTER_CYCLES (FAULT_FILTER_CYCLES),
  .STRETCH_CYCLES      (STRETCH_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_bad (supply_bad),
  .btn_n      (btn_n),
  .sys_rst    (sys_rst),
  .sys_rst_n  (sys_rst_n),
  .rst_done   (rst_done)
);

// File: tb/tb_rst_stretch_ctrl.sv
`timescale 1ns/1ps
module tb_rst_stretch_ctrl;

  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int FLT  = 5;
  localparam int STR  = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_bad;
  logic btn_n;
  logic sys_rst, sys_rst_n, rst_done;

  always #2.5 clk = ~clk;

  rst_stretch_ctrl #(
    .SYNC_STAGES         (SYNC),
    .DEBOUNCE_CYCLES     (DEB),
    .FAULT_FILTER_CYCLES (FLT),
    .STRETCH_CYCLES      (STR)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_bad (supply_bad),
    .btn_n      (btn_n),
    .sys_rst    (sys_rst),
    .sys_rst_n  (sys_rst_n),
    .rst_done   (rst_done)
  );

  typedef struct {
    int    cyc;
    bit    rst;
    bit    done;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: insert an expectation keeping the queue ordered by cycle.
  task automatic expect_at(input int c, input bit r, input bit d, input string tag);
    exp_t e;
    int   pos;
    e.cyc = c; e.rst = r; e.done = d; e.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].cyc > c) begin
        pos = i;
        break;
      end
    end
    sb.insert(pos, e);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor side: compare at the falling edge of the cycle.
  always @(negedge clk) begin
    while (sb.size() != 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (sys_rst !== e.rst || sys_rst_n !== !e.rst || rst_done !== e.done) begin
        n_fail++;
        $display("FAIL %s cyc=%0d sys_rst=%0b sys_rst_n=%0b rst_done=%0b exp_rst=%0b exp_done=%0b",
                 e.tag, cyc, sys_rst, sys_rst_n, rst_done, e.rst, e.done);
      end
    end
  end

  initial begin
    int c, c2, c3;
    rst_n = 1'b0; supply_bad = 1'b0; btn_n = 1'b1;

    // R1: outputs during block reset
    @(negedge clk);
    c = cyc;
    for (int k = 1; k <= 3; k++) expect_at(c + k, 1'b1, 1'b0, "R1");
    drain();

    // R2, R9: stretch after block reset release
    rst_n = 1'b1;
    c = cyc;
    expect_at(c + STR,     1'b1, 1'b0, "R2");
    expect_at(c + STR + 1, 1'b0, 1'b1, "R2_R9");
    expect_at(c + STR + 2, 1'b0, 1'b0, "R9");
    drain();

    // R4: supply pulse one cycle too short
    supply_bad = 1'b1;
    c = cyc;
    for (int k = 1; k <= FLT + 4; k++) expect_at(c + k, 1'b0, 1'b0, "R4");
    repeat (FLT - 1) @(negedge clk);
    supply_bad = 1'b0;
    drain();

    // R3, R5: qualified supply fault and recovery
    supply_bad = 1'b1;
    c = cyc;
    expect_at(c + FLT,     1'b0, 1'b0, "R3");
    expect_at(c + FLT + 1, 1'b1, 1'b0, "R3");
    expect_at(c + 25,      1'b1, 1'b0, "R3");
    repeat (30) @(negedge clk);
    supply_bad = 1'b0;
    c2 = cyc;
    expect_at(c2 + STR + 1, 1'b1, 1'b0, "R5");
    expect_at(c2 + STR + 2, 1'b0, 1'b1, "R5");
    drain();

    // R6: button bounce shorter than the debounce window
    btn_n = 1'b0;
    c = cyc;
    for (int k = 1; k <= DEB + 8; k++) expect_at(c + k, 1'b0, 1'b0, "R6");
    repeat (DEB - 1) @(negedge clk);
    btn_n = 1'b1;
    drain();

    // R7: held press, stretch from release
    btn_n = 1'b0;
    c = cyc;
    expect_at(c + SYNC + DEB,     1'b0, 1'b0, "R7");
    expect_at(c + SYNC + DEB + 1, 1'b1, 1'b0, "R7");
    repeat (15) @(negedge clk);
    btn_n = 1'b1;
    c2 = cyc;
    expect_at(c2 + SYNC + DEB + STR,     1'b1, 1'b0, "R7");
    expect_at(c2 + SYNC + DEB + STR + 1, 1'b0, 1'b1, "R7");
    drain();

    // R8: second supply fault during a running stretch
    supply_bad = 1'b1;
    repeat (FLT + 3) @(negedge clk);
    supply_bad = 1'b0;
    c2 = cyc;
    expect_at(c2 + STR + 2, 1'b1, 1'b0, "R8");
    repeat (10) @(negedge clk);
    supply_bad = 1'b1;
    repeat (FLT + 2) @(negedge clk);
    supply_bad = 1'b0;
    c3 = cyc;
    expect_at(c3 + STR + 1, 1'b1, 1'b0, "R8");
    expect_at(c3 + STR + 2, 1'b0, 1'b1, "R8");
    drain();

    // R8: button press during a supply-recovery stretch
    supply_bad = 1'b1;
    repeat (FLT + 3) @(negedge clk);
    supply_bad = 1'b0;
    c2 = cyc;
    expect_at(c2 + STR + 2, 1'b1, 1'b0, "R8");
    repeat (5) @(negedge clk);
    btn_n = 1'b0;
    repeat (10) @(negedge clk);
    btn_n = 1'b1;
    c3 = cyc;
    expect_at(c3 + SYNC + DEB + STR,     1'b1, 1'b0, "R8");
    expect_at(c3 + SYNC + DEB + STR + 1, 1'b0, 1'b1, "R8");
    drain();

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog cyc=%0d pending=%0d expected=0", cyc, sb.size());
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule